// File: doc/BRIEF.md
# Nested Prioritized Interrupt Controller

This block collects a parameterized set of external interrupt lines and one non-maskable line. It keeps an enable, pending and active bit for each line. A priority value is stored for each line. Three masking controls filter what may win: a block-all mask for configurable lines, a block-all-but-non-maskable mask, and a priority threshold. The most urgent eligible request is presented to a processor core as a request flag with a line identifier. The core takes the request with a one-cycle acknowledge pulse and ends the handler with a one-cycle return pulse. A stack of saved running levels lets handlers nest by preemption.

Each line is fixed at build time as level-type or pulse-type. A level line stays pending while its input is high and is taken again after its handler returns if the input is still high. A pulse line is pending on a sampled rising edge. It can be pending and active at once, and several edges merge into one pending event. A privileged, full-word register port gives software set/clear access to enables and pending bits, plus access to priorities, masks and the threshold.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, all enable, pending and active bits, all priorities, both masks and the threshold are zero. No request is presented (`irqReq` low).
- R2: An access with `regSize` other than 2 (full word), or with `regPriv` low, sets `respErr` and returns zero read data. A write with such an error changes no state.
- R3: Word address 0x00+b writes ones to set enables, and 0x08+b writes ones to clear them; both read the enables. Word 0x10+b sets pending bits and 0x18+b clears them; both read the pending bits. Word 0x20+b reads the active bits. Bank b covers lines 32b..32b+31, bit n is line 32b+n, and bits that are zero in the write data leave state unchanged.
- R4: The priority of line i is stored at word 0x40+i/4, byte i%4. Only the upper PRIO_BITS bits of each byte are kept, and the low bits read as zero.
- R5: Among pending, enabled, unmasked lines, the numerically smallest priority wins. Equal priorities go to the lowest line number. `irqId` gives the winning line.
- R6: A winner is requested only if its level is strictly more urgent than the running level; the level of a line is its priority. On an acknowledge, the winner's pending bit clears, its active bit sets and the running level is pushed. A return pops the stack and clears the active bit of the most recently taken line.
- R7: A level-type line sets pending whenever its input is high and the line is not active. After its handler returns, a still-high input makes it pending again.
- R8: A pulse-type line sets pending on a rising edge of its input sampled at the clock. An edge during the line's handler leaves it both pending and active. Several edges before service give one pending event.
- R9: The mask at word 0x30 bit 0 and the mask at word 0x31 bit 0 each block all configurable lines when set.
- R10: The threshold at word 0x32 (upper PRIO_BITS of byte 0) masks lines whose priority is greater than or equal to it when it is non-zero. A zero threshold masks nothing.
- R11: A rising edge on `nmiIn` makes the non-maskable request pending. It is never masked, needs no enable, outranks every line and is reported with `irqIsNmi` high and `irqId` equal to NUM_LINES.
- R12: An acknowledge with no request, and a return with no handler running, change no state. A return in the same cycle as an acknowledge takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineIn | input | NUM_LINES | External interrupt inputs |
| nmiIn | input | 1 | Non-maskable interrupt input (edge) |
| regValid | input | 1 | Register access strobe |
| regWrite | input | 1 | 1 = write, 0 = read |
| regSize | input | 2 | Access size: 0 byte, 1 half, 2 word |
| regPriv | input | 1 | Access is privileged |
| regAddr | input | 7 | Word address |
| regWdata | input | 32 | Write data |
| respRdata | output | 32 | Read data, valid with regValid in the same cycle |
| respErr | output | 1 | Access error, same cycle |
| ack | input | 1 | Core takes the presented request |
| ret | input | 1 | Core returns from the current handler |
| irqReq | output | 1 | A request beats the running level |
| irqId | output | $clog2(NUM_LINES+1) | Winning line, NUM_LINES for non-maskable |
| irqIsNmi | output | 1 | Winner is the non-maskable line |

## Verification
A wrong pending or enable bit shows at `irqReq`/`irqId` in the cycle after the register write or input edge that caused it. It also shows in the pending read word at once. A corrupted running level or stack entry stays hidden until a later request of equal or lower urgency is wrongly presented or withheld. Some such faults only show after one or more return pulses, so the bench walks nested take/return sequences and checks the request after each pop. Level re-pending and pulse merging show only across a full acknowledge/return cycle, so those sequences are checked cycle by cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef struct packed {
    logic        setEn;
    logic        clrEn;
    logic        setPend;
    logic        clrPend;
    logic        prioWr;
    logic        maskAllWr;
    logic        maskNmiWr;
    logic        thrWr;
    logic [2:0]  bank;
    logic [5:0]  prioWord;
    logic [31:0] data;
  } regStrobe_t;
endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl import irq_pkg::*; #(
  parameter int NUM_LINES = 8,
  parameter int PRIO_BITS = 3
) (
  input  logic                           regValid,
  input  logic                           regWrite,
  input  logic [1:0]                     regSize,
  input  logic                           regPriv,
  input  logic [6:0]                     regAddr,
  input  logic [31:0]                    regWdata,
  input  logic [NUM_LINES-1:0]           enState,
  input  logic [NUM_LINES-1:0]           pendState,
  input  logic [NUM_LINES-1:0]           actState,
  input  logic [NUM_LINES*PRIO_BITS-1:0] prioFlat,
  input  logic                           maskAll,
  input  logic                           maskNmi,
  input  logic [PRIO_BITS-1:0]           thrState,
  output regStrobe_t                     strb,
  output logic [31:0]                    respRdata,
  output logic                           respErr
);
  localparam int NUM_BANKS  = (NUM_LINES + 31) / 32;
  localparam int PRIO_WORDS = (NUM_LINES + 3) / 4;
  localparam int PAD_W      = NUM_BANKS * 32;

  logic [PAD_W-1:0] enPad, pendPad, actPad;
  logic             bankOk, prioOk, accOk, doWr;
  logic [3:0]       grp;

  always_comb begin
    enPad = '0;   enPad[NUM_LINES-1:0]   = enState;
    pendPad = '0; pendPad[NUM_LINES-1:0] = pendState;
    actPad = '0;  actPad[NUM_LINES-1:0]  = actState;
  end

  assign grp     = regAddr[6:3];
  assign bankOk  = 32'(regAddr[2:0]) < NUM_BANKS;
  assign prioOk  = regAddr[6] && (32'(regAddr[5:0]) < PRIO_WORDS);
  assign respErr = regValid && ((regSize != 2'd2) || !regPriv);
  assign accOk   = regValid && !respErr;
  assign doWr    = accOk && regWrite;

  always_comb begin
    strb = '0;
    strb.bank     = regAddr[2:0];
    strb.prioWord = regAddr[5:0];
    strb.data     = regWdata;
    strb.setEn    = doWr && bankOk && grp == 4'd0;
    strb.clrEn    = doWr && bankOk && grp == 4'd1;
    strb.setPend  = doWr && bankOk && grp == 4'd2;
    strb.clrPend  = doWr && bankOk && grp == 4'd3;
    strb.maskAllWr = doWr && regAddr == 7'h30;
    strb.maskNmiWr = doWr && regAddr == 7'h31;
    strb.thrWr     = doWr && regAddr == 7'h32;
    strb.prioWr    = doWr && prioOk;
  end

  always_comb begin
    respRdata = '0;
    if (accOk && !regWrite) begin
      if (grp <= 4'd4 && bankOk) begin
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (32'(regAddr[2:0]) == b) begin
            if (grp <= 4'd1)      respRdata = enPad[b*32 +: 32];
            else if (grp <= 4'd3) respRdata = pendPad[b*32 +: 32];
            else                  respRdata = actPad[b*32 +: 32];
          end
        end
      end else if (regAddr == 7'h30) begin
        respRdata = {31'd0, maskAll};
      end else if (regAddr == 7'h31) begin
        respRdata = {31'd0, maskNmi};
      end else if (regAddr == 7'h32) begin
        respRdata = {24'd0, 8'(thrState) << (8 - PRIO_BITS)};
      end else if (prioOk) begin
        for (int i = 0; i < NUM_LINES; i++) begin
          if (32'(regAddr[5:0]) == i / 4)
            respRdata[(i%4)*8 +: 8] = 8'(prioFlat[i*PRIO_BITS +: PRIO_BITS]) << (8 - PRIO_BITS);
        end
      end
    end
  end

  // R2: a rejected access never produces a write strobe
  always_comb begin
    assert_err_no_strobe_R2: assert (!(respErr && (strb.setEn || strb.clrEn || strb.setPend ||
      strb.clrPend || strb.prioWr || strb.maskAllWr || strb.maskNmiWr || strb.thrWr)));
  end
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath import irq_pkg::*; #(
  parameter int NUM_LINES = 8,
  parameter int PRIO_BITS = 3,
  parameter logic [NUM_LINES-1:0] LEVEL_MASK = '0,
  localparam int ID_W = $clog2(NUM_LINES + 1)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  regStrobe_t                     strb,
  input  logic [NUM_LINES-1:0]           lineIn,
  input  logic                           nmiIn,
  input  logic                           ack,
  input  logic                           ret,
  output logic [NUM_LINES-1:0]           enState,
  output logic [NUM_LINES-1:0]           pendState,
  output logic [NUM_LINES-1:0]           actState,
  output logic [NUM_LINES*PRIO_BITS-1:0] prioFlat,
  output logic                           maskAll,
  output logic                           maskNmi,
  output logic [PRIO_BITS-1:0]           thrState,
  output logic                           irqReq,
  output logic [ID_W-1:0]                irqId,
  output logic                           irqIsNmi
);
  localparam int LVL_W       = PRIO_BITS + 2;
  localparam int STACK_DEPTH = (1 << PRIO_BITS) + 1;
  localparam int SP_W        = $clog2(STACK_DEPTH + 1);
  localparam logic [LVL_W-1:0] IDLE_LVL = LVL_W'((1 << PRIO_BITS) + 1);
  localparam logic [ID_W-1:0]  NMI_ID   = ID_W'(NUM_LINES);

  logic [NUM_LINES-1:0] en, pend, act, inPrev, nPend, nAct;
  logic [PRIO_BITS-1:0] prio [NUM_LINES];
  logic [PRIO_BITS-1:0] thr;
  logic                 mAll, mNmi, nmiPrev, nmiPend, nmiAct;
  logic [LVL_W-1:0]     runLvl, winLvl;
  logic [ID_W-1:0]      winId;
  logic                 winNmi, take, pop;
  logic [SP_W-1:0]      sp;
  logic [ID_W-1:0]      stackId  [STACK_DEPTH];
  logic [LVL_W-1:0]     stackLvl [STACK_DEPTH];
  logic [ID_W-1:0]      popId;

  // arbitration: smallest level wins, lowest index on ties, non-maskable first
  always_comb begin
    winLvl = IDLE_LVL;
    winId  = '0;
    winNmi = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (pend[i] && en[i] && !mAll && !mNmi && !(thr != '0 && prio[i] >= thr) &&
          (LVL_W'(prio[i]) + LVL_W'(1)) < winLvl) begin
        winLvl = LVL_W'(prio[i]) + LVL_W'(1);
        winId  = ID_W'(i);
      end
    end
    if (nmiPend) begin
      winLvl = '0;
      winId  = NMI_ID;
      winNmi = 1'b1;
    end
  end

  assign irqReq   = winLvl < runLvl;
  assign irqId    = winId;
  assign irqIsNmi = winNmi;
  assign pop      = ret && (sp != '0);
  assign take     = ack && irqReq && !ret;
  assign popId    = pop ? stackId[sp - SP_W'(1)] : '0;

  always_comb begin
    nPend = pend;
    nAct  = act;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (32'(strb.bank) == i / 32) begin
        if (strb.setPend && strb.data[i%32]) nPend[i] = 1'b1;
        if (strb.clrPend && strb.data[i%32]) nPend[i] = 1'b0;
      end
      if (take && !winNmi && winId == ID_W'(i)) begin
        nPend[i] = 1'b0;
        nAct[i]  = 1'b1;
      end
      if (pop && popId == ID_W'(i)) nAct[i] = 1'b0;
      if (LEVEL_MASK[i]) begin
        if (lineIn[i] && !act[i] && !(take && !winNmi && winId == ID_W'(i))) nPend[i] = 1'b1;
      end else if (lineIn[i] && !inPrev[i]) begin
        nPend[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      en <= '0; pend <= '0; act <= '0; inPrev <= '0;
      mAll <= 1'b0; mNmi <= 1'b0; thr <= '0;
      nmiPrev <= 1'b0; nmiPend <= 1'b0; nmiAct <= 1'b0;
      runLvl <= IDLE_LVL; sp <= '0;
      for (int i = 0; i < NUM_LINES; i++) prio[i] <= '0;
    end else begin
      inPrev  <= lineIn;
      nmiPrev <= nmiIn;
      pend    <= nPend;
      act     <= nAct;
      for (int i = 0; i < NUM_LINES; i++) begin
        if (32'(strb.bank) == i / 32) begin
          if (strb.setEn && strb.data[i%32]) en[i] <= 1'b1;
          if (strb.clrEn && strb.data[i%32]) en[i] <= 1'b0;
        end
        if (strb.prioWr && 32'(strb.prioWord) == i / 4)
          prio[i] <= strb.data[(i%4)*8 + 7 -: PRIO_BITS];
      end
      if (strb.maskAllWr) mAll <= strb.data[0];
      if (strb.maskNmiWr) mNmi <= strb.data[0];
      if (strb.thrWr)     thr  <= strb.data[7 -: PRIO_BITS];
      if (pop) begin
        runLvl <= stackLvl[sp - SP_W'(1)];
        sp     <= sp - SP_W'(1);
        if (popId == NMI_ID) nmiAct <= 1'b0;
      end else if (take) begin
        runLvl <= winLvl;
        sp     <= sp + SP_W'(1);
        if (winNmi) nmiAct <= 1'b1;
      end
      if (take && winNmi) nmiPend <= 1'b0;
      if (nmiIn && !nmiPrev) nmiPend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      stackId[sp]  <= winId;
      stackLvl[sp] <= runLvl;
    end
  end

  always_comb begin
    enState = en; pendState = pend; actState = act;
    maskAll = mAll; maskNmi = mNmi; thrState = thr;
    for (int i = 0; i < NUM_LINES; i++) prioFlat[i*PRIO_BITS +: PRIO_BITS] = prio[i];
  end

  assert_take_raises_urgency_R6: assert property (@(posedge clk) disable iff (!rstN)
    take |=> (runLvl < $past(runLvl)) && (sp == $past(sp) + SP_W'(1)));
  assert_pop_shrinks_stack_R12: assert property (@(posedge clk) disable iff (!rstN)
    pop |=> sp == $past(sp) - SP_W'(1));
  assert_stack_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    sp <= SP_W'(STACK_DEPTH));
  assert_nmi_presented_R11: assert property (@(posedge clk) disable iff (!rstN)
    (nmiPend && !nmiAct) |-> (irqReq && irqIsNmi));
  assert_masks_block_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((mAll || mNmi) && irqReq) |-> irqIsNmi);
  assert_idle_no_ret_R12: assert property (@(posedge clk) disable iff (!rstN)
    (ret && sp == '0) |=> $stable(act));
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl import irq_pkg::*; #(
  parameter int NUM_LINES = 8,
  parameter int PRIO_BITS = 3,
  parameter logic [NUM_LINES-1:0] LEVEL_MASK = 8'h0F,
  localparam int ID_W = $clog2(NUM_LINES + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] lineIn,
  input  logic                 nmiIn,
  input  logic                 regValid,
  input  logic                 regWrite,
  input  logic [1:0]           regSize,
  input  logic                 regPriv,
  input  logic [6:0]           regAddr,
  input  logic [31:0]          regWdata,
  output logic [31:0]          respRdata,
  output logic                 respErr,
  input  logic                 ack,
  input  logic                 ret,
  output logic                 irqReq,
  output logic [ID_W-1:0]      irqId,
  output logic                 irqIsNmi
);
  regStrobe_t                     strb;
  logic [NUM_LINES-1:0]           enState, pendState, actState;
  logic [NUM_LINES*PRIO_BITS-1:0] prioFlat;
  logic                           maskAll, maskNmi;
  logic [PRIO_BITS-1:0]           thrState;

  irq_ctrl #(.NUM_LINES(NUM_LINES), .PRIO_BITS(PRIO_BITS)) i_ctrl (
    .regValid(regValid), .regWrite(regWrite), .regSize(regSize), .regPriv(regPriv),
    .regAddr(regAddr), .regWdata(regWdata), .enState(enState), .pendState(pendState),
    .actState(actState), .prioFlat(prioFlat), .maskAll(maskAll), .maskNmi(maskNmi),
    .thrState(thrState), .strb(strb), .respRdata(respRdata), .respErr(respErr));

  irq_datapath #(.NUM_LINES(NUM_LINES), .PRIO_BITS(PRIO_BITS), .LEVEL_MASK(LEVEL_MASK)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .lineIn(lineIn), .nmiIn(nmiIn), .ack(ack), .ret(ret),
    .enState(enState), .pendState(pendState), .actState(actState), .prioFlat(prioFlat),
    .maskAll(maskAll), .maskNmi(maskNmi), .thrState(thrState),
    .irqReq(irqReq), .irqId(irqId), .irqIsNmi(irqIsNmi));
endmodule

// File: tb/test_irq_nest_ctrl.sv
`timescale 1ns/1ps
module test_irq_nest_ctrl;
  logic clk = 0, rstN = 0;
  logic [7:0] lineIn = '0;
  logic nmiIn = 0, regValid = 0, regWrite = 0, regPriv = 1, ack = 0, ret = 0;
  logic [1:0] regSize = 2'd2;
  logic [6:0] regAddr = '0;
  logic [31:0] regWdata = '0, respRdata;
  logic respErr, irqReq, irqIsNmi;
  logic [3:0] irqId;
  int checks = 0, errors = 0;
  int prioM [8];

  always #4 clk = ~clk;

  irq_nest_ctrl i_irq_nest_ctrl (.clk(clk), .rstN(rstN), .lineIn(lineIn), .nmiIn(nmiIn),
    .regValid(regValid), .regWrite(regWrite), .regSize(regSize), .regPriv(regPriv),
    .regAddr(regAddr), .regWdata(regWdata), .respRdata(respRdata), .respErr(respErr),
    .ack(ack), .ret(ret), .irqReq(irqReq), .irqId(irqId), .irqIsNmi(irqIsNmi));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0; lineIn = '0; nmiIn = 0; ack = 0; ret = 0;
    @(negedge clk); @(negedge clk); rstN = 1;
    for (int i = 0; i < 8; i++) prioM[i] = 0;
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d, logic [1:0] sz = 2'd2, logic pv = 1);
    @(negedge clk); regValid = 1; regWrite = 1; regAddr = a; regWdata = d; regSize = sz; regPriv = pv;
    @(negedge clk); regValid = 0; regWrite = 0; regSize = 2'd2; regPriv = 1;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d, output logic e,
                    input logic [1:0] sz = 2'd2, input logic pv = 1);
    @(negedge clk); regValid = 1; regWrite = 0; regAddr = a; regSize = sz; regPriv = pv;
    #1; d = respRdata; e = respErr;
    regValid = 0; regSize = 2'd2; regPriv = 1;
  endtask

  task automatic pulseAck(); @(negedge clk); ack = 1; @(negedge clk); ack = 0; endtask
  task automatic pulseRet(); @(negedge clk); ret = 1; @(negedge clk); ret = 0; endtask
  task automatic pulseLine(int n); @(negedge clk); lineIn[n] = 1; @(negedge clk); lineIn[n] = 0; endtask

  task automatic chkReq(string tag, logic r, logic [3:0] id);
    @(negedge clk); #1;
    chk({tag, " req"}, 32'(irqReq), 32'(r));
    if (r) chk({tag, " id"}, 32'(irqId), 32'(id));
  endtask

  task automatic chkReg(string tag, logic [6:0] a, logic [31:0] exp);
    logic [31:0] d; logic e;
    rd(a, d, e);
    chk(tag, d, exp);
  endtask

  function automatic int expWin(logic [7:0] p, logic [7:0] e);
    int best = -1;
    for (int i = 0; i < 8; i++)
      if (p[i] && e[i] && (best < 0 || prioM[i] < prioM[best])) best = i;
    return best;
  endfunction

  function automatic logic [31:0] prioWord(int w);
    logic [31:0] v = '0;
    for (int j = 0; j < 4; j++) v[j*8 +: 8] = 8'(prioM[w*4+j] << 5);
    return v;
  endfunction

  initial begin
    #1500000; errors++; $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors); $finish;
  end

  initial begin
    logic [31:0] d; logic e;
    void'($urandom(32'd1234));
    doReset();
    // R1 reset state
    chkReq("R1", 0, 0);
    chkReg("R1 enable", 7'h00, 0);
    chkReg("R1 pending", 7'h10, 0);
    chkReg("R1 active", 7'h20, 0);
    chkReg("R1 prio", 7'h40, 0);
    chkReg("R1 thr", 7'h32, 0);

    // R2 error responses
    wr(7'h00, 32'hFF, 2'd1, 1);
    chkReg("R2 subword write ignored", 7'h00, 0);
    wr(7'h00, 32'hFF, 2'd2, 0);
    chkReg("R2 unpriv write ignored", 7'h00, 0);
    rd(7'h20, d, e, 2'd0, 1);
    chk("R2 err flag", 32'(e), 1);
    chk("R2 err data", d, 0);

    // R3 set/clear enable and pending
    wr(7'h00, 32'h5A);
    wr(7'h08, 32'h0A);
    chkReg("R3 enable", 7'h00, 32'h50);
    chkReg("R3 enable alias", 7'h08, 32'h50);
    wr(7'h10, 32'h30);
    chkReg("R3 pending", 7'h18, 32'h30);
    wr(7'h18, 32'h30);
    chkReg("R3 pending clear", 7'h10, 0);

    // R4 priority field layout
    wr(7'h40, 32'hFFFF_FFFF);
    chkReg("R4 low bits zero", 7'h40, 32'hE0E0_E0E0);
    wr(7'h41, 32'h2060_A0C0);
    chkReg("R4 word1", 7'h41, 32'h2060_A0C0);

    // R5 random arbitration
    doReset();
    for (int it = 0; it < 40; it++) begin
      logic [7:0] ev, pv;
      int w;
      for (int i = 0; i < 8; i++) prioM[i] = $urandom_range(0, 7);
      ev = 8'($urandom); pv = 8'($urandom);
      wr(7'h40, prioWord(0)); wr(7'h41, prioWord(1));
      wr(7'h00, 32'(ev)); wr(7'h08, 32'(~ev));
      wr(7'h10, 32'(pv));
      w = expWin(pv, ev);
      chkReq("R5 random", w >= 0, 4'(w < 0 ? 0 : w));
      wr(7'h18, 32'hFF);
    end
    // R5 tie break
    doReset();
    wr(7'h00, 32'h24); wr(7'h10, 32'h24);
    chkReq("R5 tie", 1, 2);

    // R6 nesting
    doReset();
    wr(7'h41, 32'h4080_8000);
    wr(7'h00, 32'hE0);
    wr(7'h10, 32'h20);
    chkReq("R6 first", 1, 5);
    pulseAck();
    chkReg("R6 active", 7'h20, 32'h20);
    chkReg("R6 pend cleared", 7'h10, 0);
    wr(7'h10, 32'h40);
    chkReq("R6 equal no preempt", 0, 0);
    wr(7'h10, 32'h80);
    chkReq("R6 preempt", 1, 7);
    pulseAck();
    chkReg("R6 nested active", 7'h20, 32'hA0);
    pulseRet();
    chkReg("R6 pop inner", 7'h20, 32'h20);
    chkReq("R6 restored level", 0, 0);
    pulseRet();
    chkReq("R6 back to idle", 1, 6);

    // R12 ack without request / ret with nothing running
    doReset();
    pulseAck();
    chkReg("R12 ack ignored", 7'h20, 0);
    pulseRet();
    chkReg("R12 ret ignored", 7'h20, 0);
    chkReq("R12 idle", 0, 0);

    // R7 level line 0
    doReset();
    wr(7'h00, 32'h01);
    @(negedge clk); lineIn[0] = 1;
    chkReq("R7 level pend", 1, 0);
    pulseAck();
    @(negedge clk);
    chkReg("R7 not pending while active", 7'h10, 0);
    pulseRet();
    @(negedge clk);
    chkReg("R7 re-pend", 7'h10, 32'h01);
    lineIn[0] = 0;
    wr(7'h18, 32'h01);
    chkReq("R7 cleared after drop", 0, 0);

    // R8 pulse line 4
    doReset();
    wr(7'h00, 32'h10);
    pulseLine(4);
    chkReq("R8 edge pend", 1, 4);
    pulseAck();
    pulseLine(4); @(negedge clk); pulseLine(4);
    chkReg("R8 pending while active", 7'h10, 32'h10);
    chkReg("R8 active", 7'h20, 32'h10);
    pulseRet();
    chkReq("R8 retaken", 1, 4);
    pulseAck(); pulseRet();
    chkReq("R8 merged", 0, 0);

    // R9 / R11 masks and non-maskable
    doReset();
    wr(7'h00, 32'h08); wr(7'h10, 32'h08);
    wr(7'h30, 1);
    chkReq("R9 mask all", 0, 0);
    @(negedge clk); nmiIn = 1; @(negedge clk); nmiIn = 0;
    chkReq("R11 nmi", 1, 8);
    chk("R11 nmi flag", 32'(irqIsNmi), 1);
    pulseAck();
    chkReq("R11 nmi taken", 0, 0);
    pulseRet();
    wr(7'h30, 0);
    chkReq("R9 unmask", 1, 3);
    wr(7'h31, 1);
    chkReq("R9 mask non-nmi", 0, 0);

    // R10 threshold
    doReset();
    wr(7'h40, 32'h00A0_6000);
    wr(7'h00, 32'h06); wr(7'h10, 32'h06);
    wr(7'h32, 32'h60);
    chkReq("R10 thr3 masks", 0, 0);
    wr(7'h32, 32'h80);
    chkReq("R10 thr4", 1, 1);
    wr(7'h18, 32'h02);
    chkReq("R10 prio5 masked", 0, 0);
    wr(7'h32, 0);
    chkReq("R10 thr off", 1, 2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule